// File: doc/BRIEF.md
# SD Card Command Line Sequencer

This block drives one SD command at a time on the serial command line and collects the card's reply. Software loads a 32-bit argument and then writes a command word. That write starts the exchange. The block shifts out a 48-bit frame protected by CRC7. It then waits for the reply format named in the command word: none, short (48 bits), long (136 bits), or short followed by a busy phase on data line 0. The reply's CRC and index are checked when software has enabled those checks. The reply's payload goes into four 32-bit response words. Completion and error flags collect in a write-one-to-clear flag word.

Two inhibit bits tell software when a new command may be issued. The first covers the command line. The second covers the data line. A self-clearing command-path reset abandons a stuck exchange. The block advances one serial bit on each cycle where `sd_tick` is high, so the SD clock divider stays outside.

Top module: `sd_cmd_path`

## Requirements
- R1: A write to `cmd_wdata` (accepted) is followed by 48 bits on `cmd_line_out`, MSB first, with `cmd_line_oe` high for exactly those bits. The bits are: 0, 1, index (`cmd_wdata[29:24]`), the 32-bit argument, CRC7 (x^7+x^3+1, zero seed) over the first 40 bits, then 1.
- R2: `cmd_wdata[17:16]` picks the reply: 0 none, 1 long 136-bit, 2 short 48-bit, 3 short with busy. With type 0, flag bit 0 (done) rises on the clock edge that ends the last frame bit.
- R3: After a short reply, `resp0` holds the reply's 32-bit card status field (reply bits 39:8), and flag bit 0 is set when no check fails.
- R4: After a long reply, `resp0`..`resp3` hold reply bits 127:8 right-aligned (`resp0` = bits 39:8, `resp3[23:0]` = bits 127:104, `resp3[31:24]` = 0). The CRC7 check runs over bits 127:8.
- R5: When `cmd_wdata[19]` is set, a reply CRC7 mismatch sets flag bit 17 and summary bit 15, and bit 0 stays clear. When it is clear, a mismatch raises nothing.
- R6: When `cmd_wdata[20]` is set, a short reply whose index field (bits 45:40) differs from the command index sets flag bits 19 and 15. A reply end bit of 0 sets flag bits 18 and 15.
- R7: If no start bit (0) has been sampled within 64 ticks after the frame, flag bits 16 and 15 are set and both inhibit bits clear. A start bit sampled on the 64th tick is still accepted.
- R8: `inhibit_status[0]` is high from the accepted write until the reply ends. `inhibit_status[1]` is also set when `cmd_wdata[21]` (data) is set or the type is 3.
- R9: With type 3, after the reply `inhibit_status[1]` stays high while `dat0_in` is low. The tick after `dat0_in` is seen high sets flag bit 1 and clears `inhibit_status[1]`.
- R10: A command write is ignored while an exchange or busy phase is running. It is also ignored when the data inhibit is set and the new command needs the data line. The frame in progress and both inhibit bits are left unchanged.
- R11: `irq_wr` clears the flag bits that are 1 in `irq_wdata`. A flag set by an event in the same cycle stays set.
- R12: Writing `ctrl_wdata[25]`=1 shows `ctrl_rdata[25]`=1 for one cycle. The command path then returns to idle, with `inhibit_status[0]` low and the line released, and no timeout follows.
- R13: A pulse on `dat_xfer_done` clears `inhibit_status[1]` that a data command left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_tick | input | 1 | One serial bit step per high cycle |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_wr | input | 1 | Command word write strobe, starts the command |
| cmd_wdata | input | 32 | Command word (index, type, check enables, data flag) |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 32 | Control value, bit 25 command-path reset |
| ctrl_rdata | output | 32 | Control readback, bit 25 reset pending |
| irq_wr | input | 1 | Flag clear strobe |
| irq_wdata | input | 32 | Write-one-to-clear mask |
| irq_status | output | 32 | Flags: 0 done, 1 busy end, 15 error, 16 timeout, 17 CRC, 18 end bit, 19 index |
| inhibit_status | output | 2 | Bit 0 command inhibit, bit 1 data inhibit |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| cmd_line_out | output | 1 | Serial command line drive value |
| cmd_line_oe | output | 1 | Command line drive enable |
| cmd_line_in | input | 1 | Serial command line sampled value |
| dat0_in | input | 1 | Data line 0, low while the card is busy |
| dat_xfer_done | input | 1 | Data path end pulse, releases the data inhibit |

## Verification
A software flag clear and a flag set from the sequencer can land on the same clock edge. The bench provokes this by timing a clear-all write to the very edge that ends a no-reply frame, while an earlier timeout's flags are still pending. The check passes if the done flag survives and the old timeout and summary flags are gone. A second overlap is a command write during an exchange or busy phase. It is judged by the frame on the line and by the inhibit bits staying as they were.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_BUSY
  } cmd_state_e;

  localparam logic [1:0] RSP_NONE  = 2'd0;
  localparam logic [1:0] RSP_LONG  = 2'd1;
  localparam logic [1:0] RSP_SHORT = 2'd2;
  localparam logic [1:0] RSP_BUSY  = 2'd3;

  // flag positions
  localparam int F_DONE  = 0;
  localparam int F_BUSYE = 1;
  localparam int F_ERR   = 15;
  localparam int F_TOUT  = 16;
  localparam int F_CRC   = 17;
  localparam int F_END   = 18;
  localparam int F_IDX   = 19;

  // one serial step of CRC7, polynomial x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             abort,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             line_o,
  output logic             active_o,
  output logic             last_o
);
  localparam int BODY_W  = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = BODY_W + 8;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               act_q, act_n;
  logic [BODY_W-1:0]  body;
  logic [6:0]         crc_c;

  assign body = {1'b0, 1'b1, idx, arg};

  always_comb begin
    crc_c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) crc_c = crc7_step(crc_c, body[i]);
  end

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    act_n = act_q;
    if (abort) begin
      act_n = 1'b0;
    end else if (load) begin
      sh_n  = {body, crc_c, 1'b1};
      cnt_n = '0;
      act_n = 1'b1;
    end else if (act_q && tick) begin
      sh_n = {sh_q[FRAME_W-2:0], 1'b1};
      if (cnt_q == CNT_W'(FRAME_W - 1)) act_n = 1'b0;
      else cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  assign line_o   = act_q ? sh_q[FRAME_W-1] : 1'b1;
  assign active_o = act_q;
  assign last_o   = act_q && tick && !abort && (cnt_q == CNT_W'(FRAME_W - 1));

  // R1: frame counter never passes the frame length while driving
  assert_tx_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < CNT_W'(FRAME_W)));

endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
#(
  parameter int SHORT_W = 48,
  parameter int LONG_W  = 136
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              long_fmt,
  input  logic              abort,
  input  logic              line_i,
  output logic [LONG_W-1:0] frame_o,
  output logic [6:0]        crc_o,
  output logic              done_o
);
  localparam int CNT_W        = $clog2(LONG_W);
  localparam int CRC_LO       = 8;
  localparam int LONG_CRC_HI  = LONG_W - 9;
  localparam int SHORT_CRC_HI = SHORT_W - 1;

  logic [LONG_W-1:0] fr_q, fr_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic [6:0]        crc_q, crc_n;
  logic              act_q, act_n, lng_q, lng_n, done_q, done_n;
  logic [CNT_W-1:0]  hi;

  assign hi = lng_q ? CNT_W'(LONG_CRC_HI) : CNT_W'(SHORT_CRC_HI);

  always_comb begin
    fr_n   = fr_q;
    rem_n  = rem_q;
    crc_n  = crc_q;
    act_n  = act_q;
    lng_n  = lng_q;
    done_n = 1'b0;
    if (abort) begin
      act_n = 1'b0;
    end else if (start) begin
      // start bit is 0: running CRC stays at its zero seed
      fr_n  = '0;
      crc_n = '0;
      act_n = 1'b1;
      lng_n = long_fmt;
      rem_n = long_fmt ? CNT_W'(LONG_W - 2) : CNT_W'(SHORT_W - 2);
    end else if (act_q && tick) begin
      fr_n = {fr_q[LONG_W-2:0], line_i};
      if (rem_q >= CNT_W'(CRC_LO) && rem_q <= hi) crc_n = crc7_step(crc_q, line_i);
      if (rem_q == '0) begin
        act_n  = 1'b0;
        done_n = 1'b1;
      end else begin
        rem_n = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q   <= '0;
      rem_q  <= '0;
      crc_q  <= '0;
      act_q  <= 1'b0;
      lng_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      fr_q   <= fr_n;
      rem_q  <= rem_n;
      crc_q  <= crc_n;
      act_q  <= act_n;
      lng_q  <= lng_n;
      done_q <= done_n;
    end
  end

  assign frame_o = fr_q;
  assign crc_o   = crc_q;
  assign done_o  = done_q;

  // R4: remaining-bit count stays inside the long frame while receiving
  assert_rx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (rem_q <= CNT_W'(LONG_W - 2)));

endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W         = 6,
  parameter int ARG_W         = 32,
  parameter int LONG_W        = 136,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sd_tick,
  input  logic        arg_wr,
  input  logic [31:0] arg_wdata,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  output logic [31:0] ctrl_rdata,
  input  logic        irq_wr,
  input  logic [31:0] irq_wdata,
  output logic [31:0] irq_status,
  output logic [1:0]  inhibit_status,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3,
  output logic        cmd_line_out,
  output logic        cmd_line_oe,
  input  logic        cmd_line_in,
  input  logic        dat0_in,
  input  logic        dat_xfer_done
);
  localparam int SHORT_W    = 2 + IDX_W + ARG_W + 8;
  localparam int PAY_W      = LONG_W - 16;
  localparam int RESP_WORDS = (PAY_W + ARG_W - 1) / ARG_W;
  localparam int PAD_W      = RESP_WORDS * ARG_W;
  localparam int WC_W       = $clog2(TIMEOUT_TICKS + 1);
  localparam int IDX_HI     = SHORT_W - 3;
  localparam logic [31:0] LIVE = 32'h000F_8003;

  cmd_state_e         st_q, st_n;
  logic [WC_W-1:0]    wcnt_q, wcnt_n;
  logic [IDX_W-1:0]   idx_q;
  logic [1:0]         rtype_q;
  logic               crcen_q, idxen_q, dinh_q, dinh_n, rst_q;
  logic [ARG_W-1:0]   arg_q;
  logic [31:0]        irq_q, irq_n, set;
  logic [ARG_W-1:0]   resp_q [RESP_WORDS];
  logic [ARG_W-1:0]   resp_n [RESP_WORDS];
  logic               cmd_inh, need_dat_w, accept, rx_start, upd_resp;
  logic               tx_line, tx_act, tx_last, rx_done;
  logic [LONG_W-1:0]  rx_frame;
  logic [6:0]         rx_crc;
  logic               crc_err, end_err, idx_err, rsp_err;
  logic [PAD_W-1:0]   long_pad;

  assign cmd_inh    = (st_q == ST_SEND) || (st_q == ST_WAIT) || (st_q == ST_RECV);
  assign need_dat_w = cmd_wdata[21] || (cmd_wdata[17:16] == RSP_BUSY);
  assign accept     = cmd_wr && (st_q == ST_IDLE) && !rst_q && !(dinh_q && need_dat_w);

  sd_cmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(sd_tick), .load(accept), .abort(rst_q),
    .idx(cmd_wdata[24 +: IDX_W]), .arg(arg_q),
    .line_o(tx_line), .active_o(tx_act), .last_o(tx_last));

  sd_cmd_rx #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(sd_tick), .start(rx_start),
    .long_fmt(rtype_q == RSP_LONG), .abort(rst_q), .line_i(cmd_line_in),
    .frame_o(rx_frame), .crc_o(rx_crc), .done_o(rx_done));

  assign crc_err = crcen_q && (rx_crc != rx_frame[7:1]);
  assign end_err = !rx_frame[0];
  assign idx_err = idxen_q && (rtype_q != RSP_LONG) &&
                   (rx_frame[IDX_HI -: IDX_W] != idx_q);
  assign rsp_err = crc_err || end_err || idx_err;

  // sequencing
  always_comb begin
    st_n     = st_q;
    wcnt_n   = wcnt_q;
    dinh_n   = dinh_q;
    set      = '0;
    rx_start = 1'b0;
    upd_resp = 1'b0;
    if (dat_xfer_done) dinh_n = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_n   = ST_SEND;
        dinh_n = dinh_n || need_dat_w;
      end
      ST_SEND: if (tx_last) begin
        if (rtype_q == RSP_NONE) begin
          st_n       = ST_IDLE;
          set[F_DONE] = 1'b1;
        end else begin
          st_n   = ST_WAIT;
          wcnt_n = '0;
        end
      end
      ST_WAIT: if (sd_tick) begin
        if (!cmd_line_in) begin
          st_n     = ST_RECV;
          rx_start = 1'b1;
        end else if (wcnt_q == WC_W'(TIMEOUT_TICKS - 1)) begin
          st_n        = ST_IDLE;
          set[F_TOUT] = 1'b1;
          set[F_ERR]  = 1'b1;
          dinh_n      = 1'b0;
        end else begin
          wcnt_n = wcnt_q + 1'b1;
        end
      end
      ST_RECV: if (rx_done) begin
        upd_resp = 1'b1;
        if (rsp_err) begin
          st_n       = ST_IDLE;
          set[F_ERR] = 1'b1;
          set[F_CRC] = crc_err;
          set[F_END] = end_err;
          set[F_IDX] = idx_err;
          dinh_n     = 1'b0;
        end else begin
          set[F_DONE] = 1'b1;
          st_n = (rtype_q == RSP_BUSY) ? ST_BUSY : ST_IDLE;
        end
      end
      ST_BUSY: if (sd_tick && dat0_in) begin
        st_n         = ST_IDLE;
        set[F_BUSYE] = 1'b1;
        dinh_n       = 1'b0;
      end
      default: st_n = ST_IDLE;
    endcase
    if (rst_q && cmd_inh) st_n = ST_IDLE;
  end

  // flags: clear mask first, fresh events win
  always_comb begin
    irq_n = ((irq_q & ~(irq_wr ? irq_wdata : 32'h0)) | set) & LIVE;
  end

  // response words
  assign long_pad = {{(PAD_W - PAY_W){1'b0}}, rx_frame[LONG_W-9 -: PAY_W]};
  for (genvar k = 0; k < RESP_WORDS; k++) begin : g_resp
    always_comb begin
      resp_n[k] = resp_q[k];
      if (upd_resp) begin
        if (rtype_q == RSP_LONG) resp_n[k] = long_pad[k*ARG_W +: ARG_W];
        else if (k == 0) resp_n[k] = rx_frame[8 +: ARG_W];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resp_q[k] <= '0;
      else resp_q[k] <= resp_n[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wcnt_q  <= '0;
      dinh_q  <= 1'b0;
      rst_q   <= 1'b0;
      irq_q   <= '0;
      arg_q   <= '0;
      idx_q   <= '0;
      rtype_q <= RSP_NONE;
      crcen_q <= 1'b0;
      idxen_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      wcnt_q <= wcnt_n;
      dinh_q <= dinh_n;
      rst_q  <= ctrl_wr && ctrl_wdata[25];
      irq_q  <= irq_n;
      if (arg_wr) arg_q <= arg_wdata;
      if (accept) begin
        idx_q   <= cmd_wdata[24 +: IDX_W];
        rtype_q <= cmd_wdata[17:16];
        crcen_q <= cmd_wdata[19];
        idxen_q <= cmd_wdata[20];
      end
    end
  end

  assign ctrl_rdata     = {6'b0, rst_q, 25'b0};
  assign irq_status     = irq_q;
  assign inhibit_status = {dinh_q, cmd_inh};
  assign resp0          = resp_q[0];
  assign resp1          = resp_q[1];
  assign resp2          = resp_q[2];
  assign resp3          = resp_q[3];
  assign cmd_line_out   = tx_line;
  assign cmd_line_oe    = tx_act;

  // R8: line is only driven while the command inhibit is up
  assert_idle_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_inh |-> !tx_act);
  // R9: busy phase always holds the data inhibit
  assert_busy_dinh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |-> dinh_q);
  // R5: any new error flag comes with the summary flag
  assert_err_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_q[19:16] & ~$past(irq_q[19:16]))) |-> irq_q[F_ERR]);
  // R7: timeout only raised out of the reply wait
  assert_timeout_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q[F_TOUT]) |-> ($past(st_q) == ST_WAIT));
  // R12: reset request releases the command path one cycle later
  assert_reset_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !cmd_inh);
  // R10: a write during an exchange leaves the latched command alone
  assert_ignored_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (st_q != ST_IDLE)) |=> $stable(idx_q));

endmodule

// File: tb/sd_cmd_path_bench.sv
module sd_cmd_path_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd_tick = 1'b1;
  logic arg_wr = 0, cmd_wr = 0, ctrl_wr = 0, irq_wr = 0;
  logic [31:0] arg_wdata = 0, cmd_wdata = 0, ctrl_wdata = 0, irq_wdata = 0;
  logic [31:0] ctrl_rdata, irq_status, resp0, resp1, resp2, resp3;
  logic [1:0]  inhibit_status;
  logic cmd_line_out, cmd_line_oe;
  logic cmd_line_in = 1'b1, dat0_in = 1'b1, dat_xfer_done = 1'b0;
  int checks = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sd_cmd_path u_sd_cmd_path (
    .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick),
    .arg_wr(arg_wr), .arg_wdata(arg_wdata), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .irq_wr(irq_wr), .irq_wdata(irq_wdata), .irq_status(irq_status),
    .inhibit_status(inhibit_status), .resp0(resp0), .resp1(resp1), .resp2(resp2),
    .resp3(resp3), .cmd_line_out(cmd_line_out), .cmd_line_oe(cmd_line_oe),
    .cmd_line_in(cmd_line_in), .dat0_in(dat0_in), .dat_xfer_done(dat_xfer_done));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7b(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  // mode 1 corrupts CRC, mode 3 clears end bit
  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] st, input int mode);
    logic [39:0] body = {2'b00, idx, st};
    logic [47:0] f = {body, crc7b({96'b0, body}, 40), 1'b1};
    if (mode == 1) f[1] = ~f[1];
    if (mode == 3) f[0] = 1'b0;
    return {88'b0, f};
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] p);
    return {8'h3F, p, crc7b({16'b0, p}, 120), 1'b1};
  endfunction

  task automatic clr_irq();
    @(negedge clk); irq_wr = 1; irq_wdata = '1;
    @(negedge clk); irq_wr = 0;
  endtask

  // dly >= 64: card never answers
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                         input bit crcen, input bit idxen, input bit dataf, input int dly,
                         input logic [135:0] rsp, input bit clr_at_end, input bit poke);
    logic [31:0] cw = {2'b0, idx, 2'b0, dataf, idxen, crcen, 1'b0, rt, 16'h0};
    logic [39:0] body = {1'b0, 1'b1, idx, arg};
    logic [47:0] ef = {body, crc7b({96'b0, body}, 40), 1'b1};
    logic [47:0] cap;
    bit oe_ok = 1;
    @(negedge clk); arg_wr = 1; arg_wdata = arg;
    @(negedge clk); arg_wr = 0; cmd_wr = 1; cmd_wdata = cw;
    @(negedge clk); cmd_wr = 0;
    chk(inhibit_status == {dataf || rt == 2'd3, 1'b1}, "R8 inhibit at start",
        64'(inhibit_status), 64'({dataf || rt == 2'd3, 1'b1}));
    for (int i = 0; i < 48; i++) begin
      cap[47-i] = cmd_line_out;
      if (!cmd_line_oe) oe_ok = 0;
      if (poke && i == 5) begin cmd_wr = 1; cmd_wdata = cw ^ 32'h0100_0000; end
      if (poke && i == 6) cmd_wr = 0;
      if (clr_at_end && i == 47) begin irq_wr = 1; irq_wdata = '1; end
      @(negedge clk);
      if (clr_at_end && i == 47) irq_wr = 0;
    end
    chk(cap == ef, poke ? "R10 frame kept under extra write" : "R1 frame bits", 64'(cap), 64'(ef));
    chk(oe_ok && !cmd_line_oe, "R1 drive window", 64'(cmd_line_oe), 64'(0));
    if (rt != 2'd0) begin
      if (dly >= 64) begin
        repeat (64) @(negedge clk);
      end else begin
        int n = (rt == 2'd1) ? 136 : 48;
        repeat (dly) @(negedge clk);
        for (int i = 0; i < n; i++) begin
          cmd_line_in = rsp[n-1-i];
          @(negedge clk);
        end
        cmd_line_in = 1'b1;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] st;
    logic [119:0] pay;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_status == 0 && inhibit_status == 0 && !cmd_line_oe && cmd_line_out &&
        ctrl_rdata == 0 && resp0 == 0, "R8 reset state", 64'(irq_status), 64'(0));

    // R2: no reply
    run_cmd(6'd0, 32'h0, 2'd0, 0, 0, 0, 0, '0, 0, 0);
    chk(irq_status == 32'h1 && inhibit_status == 0, "R2 done after frame", 64'(irq_status), 64'(1));
    clr_irq();

    // R3: short reply, with a write poked during the frame (R10)
    st = 32'hC0FF_EE11;
    run_cmd(6'd17, 32'h1234_5678, 2'd2, 1, 1, 0, 5, mk_short(6'd17, st, 0), 0, 1);
    chk(irq_status == 32'h1, "R3 done flag", 64'(irq_status), 64'(1));
    chk(resp0 == st, "R3 card status", 64'(resp0), 64'(st));
    chk(inhibit_status == 0, "R8 inhibit released", 64'(inhibit_status), 64'(0));
    clr_irq();

    // R4: long reply
    pay = {24'hA1B2C3, 32'hD4E5F607, 32'h18293A4B, 32'h5C6D7E8F};
    run_cmd(6'd2, 32'h0, 2'd1, 1, 0, 0, 3, mk_long(pay), 0, 0);
    chk(irq_status == 32'h1, "R4 long done", 64'(irq_status), 64'(1));
    chk(resp0 == pay[31:0] && resp1 == pay[63:32], "R4 low words", {resp1, resp0}, {pay[63:32], pay[31:0]});
    chk(resp2 == pay[95:64] && resp3 == {8'h0, pay[119:96]}, "R4 high words",
        {resp3, resp2}, {8'h0, pay[119:96], pay[95:64]});
    clr_irq();

    // R5
    run_cmd(6'd9, 32'h5, 2'd2, 1, 0, 0, 2, mk_short(6'd9, 32'h77, 1), 0, 0);
    chk(irq_status == 32'h0002_8000, "R5 CRC error", 64'(irq_status), 64'h28000);
    clr_irq();
    run_cmd(6'd9, 32'h5, 2'd2, 0, 0, 0, 2, mk_short(6'd9, 32'h77, 1), 0, 0);
    chk(irq_status == 32'h1, "R5 CRC check off", 64'(irq_status), 64'(1));
    clr_irq();

    // R6
    run_cmd(6'd13, 32'h0, 2'd2, 1, 1, 0, 1, mk_short(6'd14, 32'h9, 0), 0, 0);
    chk(irq_status == 32'h0008_8000, "R6 index error", 64'(irq_status), 64'h88000);
    clr_irq();
    run_cmd(6'd13, 32'h0, 2'd2, 1, 1, 0, 1, mk_short(6'd13, 32'h9, 3), 0, 0);
    chk(irq_status == 32'h0004_8000, "R6 end bit error", 64'(irq_status), 64'h48000);
    clr_irq();

    // R7
    run_cmd(6'd8, 32'h1AA, 2'd2, 1, 1, 0, 63, mk_short(6'd8, 32'h1AA, 0), 0, 0);
    chk(irq_status == 32'h1 && resp0 == 32'h1AA, "R7 start on last tick", 64'(irq_status), 64'(1));
    clr_irq();
    run_cmd(6'd8, 32'h1AA, 2'd2, 1, 1, 0, 64, '0, 0, 0);
    chk(irq_status == 32'h0001_8000 && inhibit_status == 0, "R7 timeout", 64'(irq_status), 64'h18000);

    // R11: clear-all lands on the completing edge
    run_cmd(6'd0, 32'h0, 2'd0, 0, 0, 0, 0, '0, 1, 0);
    chk(irq_status == 32'h1, "R11 set wins over clear", 64'(irq_status), 64'(1));
    @(negedge clk); irq_wr = 1; irq_wdata = 32'h1;
    @(negedge clk); irq_wr = 0;
    chk(irq_status == 32'h0, "R11 clear one flag", 64'(irq_status), 64'(0));

    // R9 busy wait, with an ignored data command (R10)
    dat0_in = 1'b0;
    run_cmd(6'd7, 32'h0, 2'd3, 1, 1, 0, 4, mk_short(6'd7, 32'h700, 0), 0, 0);
    chk(irq_status == 32'h1 && inhibit_status == 2'b10, "R9 busy held", 64'(inhibit_status), 64'(2));
    repeat (5) @(negedge clk);
    cmd_wr = 1; cmd_wdata = {2'b0, 6'd18, 2'b0, 1'b1, 3'b0, 2'd2, 16'h0};
    @(negedge clk); cmd_wr = 0;
    @(negedge clk);
    chk(!cmd_line_oe && inhibit_status == 2'b10, "R10 write ignored in busy", 64'(inhibit_status), 64'(2));
    dat0_in = 1'b1;
    @(negedge clk);
    chk(irq_status == 32'h3 && inhibit_status == 0, "R9 busy end", 64'(irq_status), 64'(3));
    clr_irq();

    // R13
    run_cmd(6'd17, 32'h40, 2'd2, 1, 1, 1, 2, mk_short(6'd17, 32'h900, 0), 0, 0);
    chk(inhibit_status == 2'b10, "R13 data inhibit held", 64'(inhibit_status), 64'(2));
    dat_xfer_done = 1;
    @(negedge clk); dat_xfer_done = 0;
    chk(inhibit_status == 2'b00, "R13 data inhibit released", 64'(inhibit_status), 64'(0));
    clr_irq();

    // R12
    @(negedge clk); arg_wr = 1; arg_wdata = 32'h3;
    @(negedge clk); arg_wr = 0; cmd_wr = 1; cmd_wdata = {2'b0, 6'd3, 6'b0, 2'd2, 16'h0};
    @(negedge clk); cmd_wr = 0;
    repeat (52) @(negedge clk);
    chk(inhibit_status[0] == 1'b1, "R12 waiting before reset", 64'(inhibit_status), 64'(1));
    ctrl_wr = 1; ctrl_wdata = 32'h0200_0000;
    @(negedge clk); ctrl_wr = 0;
    chk(ctrl_rdata[25] == 1'b1, "R12 reset pending", 64'(ctrl_rdata), 64'h2000000);
    @(negedge clk);
    chk(ctrl_rdata[25] == 1'b0 && inhibit_status[0] == 1'b0 && !cmd_line_oe,
        "R12 self clear", 64'(ctrl_rdata), 64'(0));
    repeat (80) @(negedge clk);
    chk(irq_status == 0, "R12 no timeout after reset", 64'(irq_status), 64'(0));

    // random short commands
    for (int k = 0; k < 20; k++) begin
      logic [5:0] ix = 6'($urandom_range(0, 63));
      logic [31:0] ag = $urandom;
      logic [31:0] sv = $urandom;
      bit ce = 1'($urandom_range(0, 1));
      bit ie = 1'($urandom_range(0, 1));
      int mode = $urandom_range(0, 3);
      int d = $urandom_range(0, 40);
      logic [31:0] ex;
      logic [5:0] rix = (mode == 2) ? ix ^ 6'h21 : ix;
      ex = 32'h1;
      if (mode == 1 && ce) ex = 32'h0002_8000;
      if (mode == 2 && ie) ex = 32'h0008_8000;
      if (mode == 3) ex = 32'h0004_8000;
      run_cmd(ix, ag, 2'd2, ce, ie, 0, d, mk_short(rix, sv, mode), 0, 0);
      chk(irq_status == ex, "R5 R6 random flags", 64'(irq_status), 64'(ex));
      chk(resp0 == sv, "R3 random status", 64'(resp0), 64'(sv));
      clr_irq();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule